// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase signals of an incremental encoder, plus its index and home marks, into a signed position count. Every edge of either phase is counted (x4 decoding). The order in which the phases move gives the direction. A transition in which both phases change within one sample is rejected and raises a sticky error flag.

A 3-bit initialization-mode field sets how the counter reacts to events. It can ignore the index, clear on every index, or preload once on the next index. It can also preload on the first or the second index after a home mark, clear when the count equals a compare value, or wrap between a low and a high limit. A 2-bit match field names the phase state that an index pulse must coincide with. A 2-bit count-mode field turns the whole counter into a free-running timer. The raw inputs pass through a two-stage synchronizer. The sample clock is assumed to run at least twice as fast as the fastest expected phase edge.

Control and status pins are plain, level-valued signals. The block has no data stream and so no valid/ready handshake. A register write completes in the cycle it is presented, and reads are combinational from the read address.

Top module: `qepc_top`

## Requirements
- R1: With count-mode bit 1 clear and the enable set, each single-phase change of the synchronized {A,B} pair adjusts the position by one. The sequence 00→10→11→01→00 counts up, and the reverse counts down. The change shows in the position three clocks after it reaches the pins. Status bit 1 holds the direction of the last step (1 = up).
- R2: A change of both phases in one sample leaves the position unchanged and sets status bit 0. That bit stays set until any write to the status register (address 6).
- R3: With the enable (control bit 0) clear, the position holds, and every register can still be written and read back.
- R4: An index event is a rising edge of the synchronized index input. It takes effect only when the match field (control bits 5:4, bit 5 = B, bit 4 = A) is nonzero and equals the current {B,A}. A match field of 00 disables index events.
- R5: Initialization mode (control bits 3:1) 001 clears the position on each qualified index event. Modes 000 and 111 leave the position untouched by index events.
- R6: Mode 010 loads the initialization register (address 2) on the first qualified index event after the control register was last written, and ignores later ones.
- R7: After a rising edge on the home input, mode 011 loads the initialization register on the first qualified index event and mode 100 on the second, each once per home edge.
- R8: Mode 101 clears the position in the clock after it equals the compare register (address 3).
- R9: Mode 110 counts up from the high limit (address 4) to the low limit (address 5), and down from the low limit to the high limit. Limits are signed.
- R10: With count-mode bit 1 set (control bit 7), the position increments once per clock while enabled, and the initialization mode is ignored.
- R11: A write to the position register (address 1) sets the position on the next clock and overrides any count or event in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_a | input | 1 | Raw phase A |
| enc_b | input | 1 | Raw phase B |
| enc_idx | input | 1 | Raw index mark |
| enc_home | input | 1 | Raw home mark |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 control, 1 position, 2 init, 3 compare, 4 high, 5 low, 6 status) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address, same map |
| rd_data | output | 32 | Read data |
| pos_out | output | 32 | Current position |
| dir_up | output | 1 | Direction of the last counted step |
| phase_err | output | 1 | Sticky invalid-transition flag |

## Verification
Bad state in the phase history or in the home and next-index trackers shows up at the position port. It appears as a miscount or as a preload that is missing or repeated, three clocks after the offending edge reaches the pins. The directed scenarios therefore read the position after each edge or index pulse, not only at the end of a sequence. Loss of the error flag shows on the status read right after a later valid step. A wrong wrap or compare decision shows within one clock of the position reaching a limit.

// File: rtl/qepc_pkg.sv
package qepc_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [2:0] {
    IM_NONE  = 3'd0,
    IM_EVERY = 3'd1,
    IM_NEXT  = 3'd2,
    IM_HOME1 = 3'd3,
    IM_HOME2 = 3'd4,
    IM_CMP   = 3'd5,
    IM_MOD   = 3'd6,
    IM_RSVD  = 3'd7
  } init_mode_e;

  typedef struct packed {
    logic [1:0] cmode;
    logic [1:0] imv;
    init_mode_e imode;
    logic       en;
  } ctrl_t;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_POS  = 3'd1;
  localparam logic [ADDR_W-1:0] A_INIT = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP  = 3'd3;
  localparam logic [ADDR_W-1:0] A_HIGH = 3'd4;
  localparam logic [ADDR_W-1:0] A_LOW  = 3'd5;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd6;
endpackage

// File: rtl/qepc_decode.sv
module qepc_decode #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a_raw,
  input  logic b_raw,
  input  logic idx_raw,
  input  logic home_raw,
  output logic a_s,
  output logic b_s,
  output logic step_up,
  output logic step_dn,
  output logic bad,
  output logic idx_rise,
  output logic home_rise
);
  localparam int NSIG = 4;

  logic [NSIG-1:0] sync_q [SYNC_STAGES];
  logic [1:0]      ab_prev;
  logic            idx_prev, home_prev;
  logic [1:0]      ab_cur;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= '0;
        else if (g == 0) sync_q[g] <= {home_raw, idx_raw, b_raw, a_raw};
        else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign a_s    = sync_q[SYNC_STAGES-1][0];
  assign b_s    = sync_q[SYNC_STAGES-1][1];
  assign ab_cur = {a_s, b_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ab_prev   <= 2'b00;
      idx_prev  <= 1'b0;
      home_prev <= 1'b0;
    end else begin
      ab_prev   <= ab_cur;
      idx_prev  <= sync_q[SYNC_STAGES-1][2];
      home_prev <= sync_q[SYNC_STAGES-1][3];
    end
  end

  function automatic logic [1:0] fwd(input logic [1:0] s);
    case (s)
      2'b00:   fwd = 2'b10;
      2'b10:   fwd = 2'b11;
      2'b11:   fwd = 2'b01;
      default: fwd = 2'b00;
    endcase
  endfunction

  assign step_up   = (ab_cur == fwd(ab_prev));
  assign step_dn   = (ab_prev == fwd(ab_cur));
  assign bad       = ((ab_cur ^ ab_prev) == 2'b11);
  assign idx_rise  = sync_q[SYNC_STAGES-1][2] & ~idx_prev;
  assign home_rise = sync_q[SYNC_STAGES-1][3] & ~home_prev;

  // R1: a sample is at most one of up, down or invalid
  p_one_kind_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_up, step_dn, bad}));
endmodule

// File: rtl/qepc_event.sv
module qepc_event
  import qepc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  init_mode_e imode,
  input  logic [1:0] imv,
  input  logic       a_s,
  input  logic       b_s,
  input  logic       idx_rise,
  input  logic       home_rise,
  input  logic       ctrl_wr,
  output logic       ev_clear,
  output logic       ev_load
);
  logic next_armed, home_armed, home_seen;
  logic qual, use_next, use_home;

  assign qual     = active && idx_rise && (imv != 2'b00) && ({b_s, a_s} == imv);
  assign use_next = qual && (imode == IM_NEXT) && next_armed;
  assign use_home = qual && home_armed &&
                    ((imode == IM_HOME1) || ((imode == IM_HOME2) && home_seen));
  assign ev_clear = qual && (imode == IM_EVERY);
  assign ev_load  = use_next || use_home;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_armed <= 1'b1;
      home_armed <= 1'b0;
      home_seen  <= 1'b0;
    end else begin
      if (ctrl_wr) next_armed <= 1'b1;
      else if (use_next) next_armed <= 1'b0;

      if (active && home_rise) begin
        home_armed <= 1'b1;
        home_seen  <= 1'b0;
      end else if (use_home) begin
        home_armed <= 1'b0;
        home_seen  <= 1'b0;
      end else if (qual && home_armed && (imode == IM_HOME2)) begin
        home_seen  <= 1'b1;
      end
    end
  end

  // R6: a one-shot preload disarms itself unless control is rewritten
  p_next_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (use_next && !ctrl_wr) |=> !next_armed);
  // R7: a home preload needs a home edge since the last one
  p_home_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (use_home && !home_rise) |=> !home_armed);
  // R4: events only come from a qualified index edge
  p_ev_from_idx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_clear || ev_load) |-> (idx_rise && imv != 2'b00));
endmodule

// File: rtl/qepc_counter.sv
module qepc_counter
  import qepc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         timer,
  input  init_mode_e   imode,
  input  logic         step_up,
  input  logic         step_dn,
  input  logic         ev_clear,
  input  logic         ev_load,
  input  logic [W-1:0] init_val,
  input  logic [W-1:0] cmp_val,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] lo,
  input  logic         pos_wr,
  input  logic [W-1:0] pos_wdata,
  output logic [W-1:0] pos,
  output logic         dir_up
);
  logic [W-1:0] nxt;
  logic         is_mod;

  assign is_mod = (imode == IM_MOD);

  always_comb begin
    nxt = pos;
    if (en) begin
      if (timer)                                nxt = pos + W'(1);
      else if (ev_clear)                        nxt = '0;
      else if (ev_load)                         nxt = init_val;
      else if (imode == IM_CMP && pos == cmp_val) nxt = '0;
      else if (step_up)                         nxt = (is_mod && pos == hi) ? lo : pos + W'(1);
      else if (step_dn)                         nxt = (is_mod && pos == lo) ? hi : pos - W'(1);
    end
    if (pos_wr) nxt = pos_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= '0;
      dir_up <= 1'b0;
    end else begin
      pos <= nxt;
      if (en && !timer && (step_up || step_dn)) dir_up <= step_up;
    end
  end

  logic in_rng;
  assign in_rng = ($signed(pos) >= $signed(lo)) && ($signed(pos) <= $signed(hi));

  // R3: disabled counter holds unless written
  p_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !pos_wr) |=> $stable(pos));
  // R11: a register write wins over everything
  p_wr_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pos_wr |=> (pos == $past(pos_wdata)));
  // R10: timer mode steps by one each clock
  p_timer_inc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && timer && !pos_wr) |=> (pos == $past(pos) + W'(1)));
  // R9: modulo counting stays inside the limits
  p_mod_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !timer && is_mod && !pos_wr && !ev_clear && !ev_load && in_rng &&
     ($signed(lo) <= $signed(hi)))
    |=> (in_rng || hi != $past(hi) || lo != $past(lo)));
  // R1: plain quadrature counting moves by at most one
  p_unit_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !timer && imode == IM_NONE && !pos_wr)
    |=> (pos == $past(pos) || pos == $past(pos) + W'(1) || pos == $past(pos) - W'(1)));
endmodule

// File: rtl/qepc_top.sv
module qepc_top
  import qepc_pkg::*;
#(
  parameter int W           = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic              enc_idx,
  input  logic              enc_home,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [W-1:0]      rd_data,
  output logic [W-1:0]      pos_out,
  output logic              dir_up,
  output logic              phase_err
);
  localparam int CW = $bits(ctrl_t);

  ctrl_t        ctrl;
  logic [W-1:0] init_r, cmp_r, hi_r, lo_r;
  logic         err_r;
  logic         a_s, b_s, step_up, step_dn, bad, idx_rise, home_rise;
  logic         ev_clear, ev_load, timer, active;
  logic         wr_ctrl, wr_pos, wr_stat;

  assign timer   = ctrl.cmode[1];
  assign active  = ctrl.en && !timer;
  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_pos  = wr_en && (wr_addr == A_POS);
  assign wr_stat = wr_en && (wr_addr == A_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      init_r <= '0;
      cmp_r  <= '0;
      hi_r   <= '0;
      lo_r   <= '0;
      err_r  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_t'(wr_data[CW-1:0]);
      if (wr_en && wr_addr == A_INIT) init_r <= wr_data;
      if (wr_en && wr_addr == A_CMP)  cmp_r  <= wr_data;
      if (wr_en && wr_addr == A_HIGH) hi_r   <= wr_data;
      if (wr_en && wr_addr == A_LOW)  lo_r   <= wr_data;
      if (wr_stat) err_r <= 1'b0;
      else if (active && bad) err_r <= 1'b1;
    end
  end

  qepc_decode #(.SYNC_STAGES(SYNC_STAGES)) u_dec (
    .clk(clk), .rst_n(rst_n), .a_raw(enc_a), .b_raw(enc_b),
    .idx_raw(enc_idx), .home_raw(enc_home), .a_s(a_s), .b_s(b_s),
    .step_up(step_up), .step_dn(step_dn), .bad(bad),
    .idx_rise(idx_rise), .home_rise(home_rise)
  );

  qepc_event u_evt (
    .clk(clk), .rst_n(rst_n), .active(active), .imode(ctrl.imode),
    .imv(ctrl.imv), .a_s(a_s), .b_s(b_s), .idx_rise(idx_rise),
    .home_rise(home_rise), .ctrl_wr(wr_ctrl),
    .ev_clear(ev_clear), .ev_load(ev_load)
  );

  qepc_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(ctrl.en), .timer(timer), .imode(ctrl.imode),
    .step_up(step_up), .step_dn(step_dn), .ev_clear(ev_clear), .ev_load(ev_load),
    .init_val(init_r), .cmp_val(cmp_r), .hi(hi_r), .lo(lo_r),
    .pos_wr(wr_pos), .pos_wdata(wr_data), .pos(pos_out), .dir_up(dir_up)
  );

  assign phase_err = err_r;

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = W'(ctrl);
      A_POS:   rd_data = pos_out;
      A_INIT:  rd_data = init_r;
      A_CMP:   rd_data = cmp_r;
      A_HIGH:  rd_data = hi_r;
      A_LOW:   rd_data = lo_r;
      A_STAT:  rd_data = W'({dir_up, err_r});
      default: rd_data = '0;
    endcase
  end

  // R2: error flag is sticky until a status write
  p_err_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (err_r && !wr_stat) |=> err_r);
  // R2: an invalid sample never moves a non-timer count
  p_bad_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && bad && !wr_pos && !ev_clear && !ev_load && ctrl.imode != IM_CMP) |=> $stable(pos_out));
endmodule

// File: tb/qepc_top_bench.sv
module qepc_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        qa = 1'b0, qb = 1'b0, qi = 1'b0, qh = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, pos_out;
  logic        dir_up, phase_err;
  logic [1:0]  ab_s = 2'b00;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  qepc_top u_qepc_top (
    .clk(clk), .rst_n(rst_n), .enc_a(qa), .enc_b(qb), .enc_idx(qi), .enc_home(qh),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .pos_out(pos_out), .dir_up(dir_up), .phase_err(phase_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic set_ab(input logic [1:0] s);
    @(negedge clk);
    {qa, qb} = s;
    ab_s = s;
    settle();
  endtask

  task automatic up(input int n);
    for (int i = 0; i < n; i++)
      case (ab_s)
        2'b00: set_ab(2'b10);
        2'b10: set_ab(2'b11);
        2'b11: set_ab(2'b01);
        default: set_ab(2'b00);
      endcase
  endtask

  task automatic dn(input int n);
    for (int i = 0; i < n; i++)
      case (ab_s)
        2'b00: set_ab(2'b01);
        2'b01: set_ab(2'b11);
        2'b11: set_ab(2'b10);
        default: set_ab(2'b00);
      endcase
  endtask

  task automatic pulse_idx();
    @(negedge clk); qi = 1'b1; settle();
    qi = 1'b0; settle();
  endtask

  task automatic pulse_home();
    @(negedge clk); qh = 1'b1; settle();
    qh = 1'b0; settle();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd1, v); chk("R3 reset position", v, 0);
    rd(3'd0, v); chk("R3 reset control", v, 0);
    rd(3'd6, v); chk("R2 reset status", v, 0);
  endtask

  task automatic t_count();
    logic [31:0] v;
    wr(3'd0, 32'h01);
    up(4);
    rd(3'd1, v); chk("R1 four up steps", v, 4);
    rd(3'd6, v); chk("R1 direction up", v, 32'h2);
    dn(6);
    rd(3'd1, v); chk("R1 six down steps", v, 32'hFFFF_FFFE);
    rd(3'd6, v); chk("R1 direction down", v, 32'h0);
  endtask

  task automatic t_invalid();
    logic [31:0] v;
    set_ab(2'b00);
    rd(3'd1, v); chk("R2 invalid holds count", v, 32'hFFFF_FFFE);
    rd(3'd6, v); chk("R2 error set", v[0], 1);
    up(1);
    rd(3'd6, v); chk("R2 error sticky", v, 32'h3);
    wr(3'd6, 0);
    rd(3'd6, v); chk("R2 error cleared", v[0], 0);
  endtask

  task automatic t_disable();
    logic [31:0] v;
    wr(3'd0, 32'h00);
    up(2);
    rd(3'd1, v); chk("R3 disabled holds", v, 32'hFFFF_FFFF);
    wr(3'd2, 32'h1234);
    rd(3'd2, v); chk("R3 register writable while disabled", v, 32'h1234);
    wr(3'd0, 32'h01);
    wr(3'd1, 10);
    rd(3'd1, v); chk("R11 position write", v, 10);
  endtask

  task automatic t_index();
    logic [31:0] v;
    while (ab_s != 2'b11) up(1);
    wr(3'd0, 32'h33);
    wr(3'd1, 10);
    pulse_idx();
    rd(3'd1, v); chk("R5 mode 001 clears on index", v, 0);
    wr(3'd0, 32'h23); wr(3'd1, 7);
    pulse_idx();
    rd(3'd1, v); chk("R4 mismatched state ignored", v, 7);
    wr(3'd0, 32'h03);
    pulse_idx();
    rd(3'd1, v); chk("R4 match field 00 ignored", v, 7);
    wr(3'd0, 32'h31);
    pulse_idx();
    rd(3'd1, v); chk("R5 mode 000 ignores index", v, 7);
    wr(3'd0, 32'h3F);
    pulse_idx();
    rd(3'd1, v); chk("R5 mode 111 ignores index", v, 7);
  endtask

  task automatic t_next();
    logic [31:0] v;
    wr(3'd2, 100);
    wr(3'd0, 32'h35);
    pulse_idx();
    rd(3'd1, v); chk("R6 next index loads", v, 100);
    wr(3'd1, 55);
    pulse_idx();
    rd(3'd1, v); chk("R6 later index ignored", v, 55);
  endtask

  task automatic t_home();
    logic [31:0] v;
    wr(3'd2, 50);
    wr(3'd0, 32'h37); wr(3'd1, 5);
    pulse_idx();
    rd(3'd1, v); chk("R7 index before home ignored", v, 5);
    pulse_home(); pulse_idx();
    rd(3'd1, v); chk("R7 first index after home loads", v, 50);
    wr(3'd1, 6);
    pulse_idx();
    rd(3'd1, v); chk("R7 one load per home", v, 6);
    wr(3'd0, 32'h39); wr(3'd1, 3);
    pulse_home(); pulse_idx();
    rd(3'd1, v); chk("R7 mode 100 skips first index", v, 3);
    pulse_idx();
    rd(3'd1, v); chk("R7 mode 100 second index loads", v, 50);
  endtask

  task automatic t_cmp();
    logic [31:0] v;
    wr(3'd3, 3); wr(3'd1, 0);
    wr(3'd0, 32'h0B);
    up(5);
    rd(3'd1, v); chk("R8 compare clears", v, 2);
  endtask

  task automatic t_mod();
    logic [31:0] v;
    wr(3'd4, 2); wr(3'd5, 32'hFFFF_FFFE);
    wr(3'd0, 32'h0D); wr(3'd1, 2);
    up(1);
    rd(3'd1, v); chk("R9 wrap high to low", v, 32'hFFFF_FFFE);
    dn(1);
    rd(3'd1, v); chk("R9 wrap low to high", v, 2);
    dn(1);
    rd(3'd1, v); chk("R9 plain down inside range", v, 1);
  endtask

  task automatic t_timer();
    logic [31:0] v;
    wr(3'd0, 32'h8B);
    wr(3'd1, 0);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R10 timer counts clocks past compare", pos_out, 10);
    wr(3'd0, 32'h8A);
    rd(3'd1, v);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R3 timer holds when disabled", pos_out, v);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_count();
    t_invalid();
    t_disable();
    t_index();
    t_next();
    t_home();
    t_cmp();
    t_mod();
    t_timer();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule